// File: doc/BRIEF.md
# Register access command sequencer

This block is a hardware master that performs register reads, writes and read-modify-writes on a power-control register space. It does this through a mailbox shared with a remote processor. A request carries an operation kind, an item count and up to five 16-bit register addresses with their data bytes. The sequencer packs the request into the mailbox payload buffer and writes the command word. It then waits for the remote side to finish and returns a status and, for reads, the result bytes.

Completion can be detected in two ways: by polling the mailbox busy flag until it drops, or by waiting for a completion interrupt pulse. A programmable cycle limit bounds the wait. A request with a bad count or an unknown operation is answered with an error at once and makes no mailbox access. The mailbox register block and the remote firmware lie outside this block.

Top module: `regacc_seq`

## Requirements
- R1: The command word is written once to mailbox offset 0x00, after the payload. It holds 0xFF in bits 7:0, the completion-notify flag (the latched `use_irq`) in bit 8, the sub-command in bits 15:12 (0 write, 1 read, 2 read-modify-write) and the size in bits 23:16. All other bits are zero.
- R2: Each address is placed little-endian as two bytes, item i at payload bytes 2i and 2i+1. Payload word k is written to offset 0x80+4k, with payload byte 4k+j in bits 8j+7:8j.
- R3: A write (`req_op`=0) places data byte i at payload byte 2n+i, where n is the item count, and uses a size of 3n.
- R4: A read (`req_op`=1) sends only addresses, with a size of 2n. On success it reads words at offsets 0x90+4k for k below ceil(n/4). It returns read-buffer byte i in `rsp_data` bits 8i+7:8i for i<n, and zero in the higher bytes.
- R5: A read-modify-write (`req_op`=2) sends item 0's address, then `req_data` byte 0 as the value and byte 1 as the mask, with a size of 4.
- R6: Payload bytes beyond the size are zero. Exactly ceil(size/4) payload words are written.
- R7: A request with a count of 0 or above 5, or with `req_op`=3, gets status 3 and makes no mailbox write or read.
- R8: In polling mode (`use_irq`=0), completion is the first cycle with `mb_busy` low, counted from the second cycle after the command write. Status is 1 if `mb_err` is high then, and 0 otherwise.
- R9: In interrupt mode (`use_irq`=1), completion is an `mb_irq` pulse, and `mb_err` is sampled in that cycle.
- R10: If no completion arrives within `timeout_cycles` wait cycles, status is 2 and no read-buffer access is made. A non-zero status also suppresses read-buffer access.
- R11: From acceptance until the response, `req_ready` stays low. Each request gets exactly one single-cycle `rsp_valid` pulse.
- R12: After reset, `req_ready` is 1 and `rsp_valid`, `mb_wr` and `mb_rd` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_op | input | 2 | 0 write, 1 read, 2 read-modify-write |
| req_count | input | 3 | Item count |
| req_addr | input | 80 | Addresses, item i in bits 16i+15:16i |
| req_data | input | 40 | Data bytes, byte i in bits 8i+7:8i |
| use_irq | input | 1 | 1 selects interrupt completion, 0 polling |
| timeout_cycles | input | 16 | Wait limit in cycles |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 2 | 0 ok, 1 I/O error, 2 timeout, 3 bad request |
| rsp_data | output | 40 | Read result bytes |
| mb_wr | output | 1 | Mailbox write strobe |
| mb_rd | output | 1 | Mailbox read strobe, data expected the next cycle |
| mb_addr | output | 8 | Mailbox byte offset |
| mb_wdata | output | 32 | Mailbox write data |
| mb_rdata | input | 32 | Mailbox read data |
| mb_busy | input | 1 | Remote side busy |
| mb_err | input | 1 | Remote side reports an error |
| mb_irq | input | 1 | Completion interrupt pulse |

## Verification
Random requests mix all three operations with counts 1 to 5, random addresses and data, both completion modes, varied latencies and random error flags. A bench mailbox model records the payload words and the command word. Comparing these against a payload built in the bench separates the three packings, and the size field separates the item-count arithmetic. Directed cases cover the counts that straddle a word boundary: 4 versus 5 on reads, and 5 on writes for a 15-byte payload. They also cover each rejection cause, a hung remote side in each completion mode, and error reporting in each mode. The last two show that completion, timeout and the read phase are told apart.

// File: rtl/regacc_pkg.sv
package regacc_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_RMW   = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_IOERR   = 2'd1,
    ST_TIMEOUT = 2'd2,
    ST_BADREQ  = 2'd3
  } status_e;

  localparam logic [7:0] MSG_POWER_REG = 8'hFF;
endpackage

// File: rtl/regacc_pack.sv
module regacc_pack
  import regacc_pkg::*;
#(
  parameter int MAX_ITEMS = 5,
  parameter int BUF_BYTES = 16,
  parameter int CNT_W     = 3,
  parameter int WCNT_W    = 3
) (
  input  logic [1:0]                 op,
  input  logic [CNT_W-1:0]           count,
  input  logic [MAX_ITEMS*16-1:0]    addr,
  input  logic [MAX_ITEMS*8-1:0]     data,
  output logic [BUF_BYTES*8-1:0]     payload,
  output logic [7:0]                 size,
  output logic [WCNT_W-1:0]          nwords
);
  logic [BUF_BYTES*8-1:0] addr_ext;
  logic [BUF_BYTES*8-1:0] data_ext;
  int n_addr;

  always_comb begin
    addr_ext = '0;
    data_ext = '0;
    addr_ext[MAX_ITEMS*16-1:0] = addr;
    data_ext[MAX_ITEMS*8-1:0]  = data;
    n_addr  = (op == OP_RMW) ? 1 : int'(count);
    payload = '0;
    for (int b = 0; b < BUF_BYTES; b++) begin
      if (b < 2*n_addr)
        payload[8*b +: 8] = addr_ext[8*b +: 8];
      else if (op == OP_WRITE && b < 3*n_addr)
        payload[8*b +: 8] = data_ext[8*(b-2*n_addr) +: 8];
      else if (op == OP_RMW && b < 4)
        payload[8*b +: 8] = data_ext[8*(b-2) +: 8];
    end
    case (op)
      OP_WRITE: size = 8'(3*int'(count));
      OP_READ:  size = 8'(2*int'(count));
      OP_RMW:   size = 8'd4;
      default:  size = 8'd0;
    endcase
    nwords = WCNT_W'((int'(size) + 3) >> 2);
  end
endmodule

// File: rtl/regacc_timer.sv
module regacc_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assign expired = run && (({1'b0, cnt} + 1'b1) >= {1'b0, limit});

  AST_TMR_FRESH: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> (cnt == '0)); // R10
endmodule

// File: rtl/regacc_seq.sv
module regacc_seq
  import regacc_pkg::*;
#(
  parameter int MAX_ITEMS = 5,
  parameter int BUF_BYTES = 16,
  parameter int CNT_W     = 3,
  parameter int TMO_W     = 16,
  parameter int MB_AW     = 8,
  parameter logic [MB_AW-1:0] CMD_OFS  = 8'h00,
  parameter logic [MB_AW-1:0] WBUF_OFS = 8'h80,
  parameter logic [MB_AW-1:0] RBUF_OFS = 8'h90
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [1:0]              req_op,
  input  logic [CNT_W-1:0]        req_count,
  input  logic [MAX_ITEMS*16-1:0] req_addr,
  input  logic [MAX_ITEMS*8-1:0]  req_data,
  input  logic                    use_irq,
  input  logic [TMO_W-1:0]        timeout_cycles,
  output logic                    rsp_valid,
  output logic [1:0]              rsp_status,
  output logic [MAX_ITEMS*8-1:0]  rsp_data,
  output logic                    mb_wr,
  output logic                    mb_rd,
  output logic [MB_AW-1:0]        mb_addr,
  output logic [31:0]             mb_wdata,
  input  logic [31:0]             mb_rdata,
  input  logic                    mb_busy,
  input  logic                    mb_err,
  input  logic                    mb_irq
);
  localparam int WCNT_W = $clog2(BUF_BYTES/4 + 1);
  localparam int RWORDS = (MAX_ITEMS + 3) / 4;

  typedef enum logic [3:0] {
    S_IDLE, S_BAD, S_WBUF, S_CMD, S_HOLD, S_WAIT, S_RREQ, S_RGAP, S_RCAP, S_RDONE
  } state_e;

  state_e                   state;
  logic [1:0]               op_q;
  logic [CNT_W-1:0]         cnt_q;
  logic [MAX_ITEMS*16-1:0]  addr_q;
  logic [MAX_ITEMS*8-1:0]   data_q;
  logic                     irq_q;
  logic [TMO_W-1:0]         tmo_q;
  logic [WCNT_W-1:0]        widx;
  logic [RWORDS*32-1:0]     rbuf_q;

  logic [BUF_BYTES*8-1:0]   payload;
  logic [7:0]               size;
  logic [WCNT_W-1:0]        nwords;
  logic [WCNT_W-1:0]        rwords;
  logic [31:0]              cmd_word;
  logic [MAX_ITEMS*8-1:0]   rd_result;
  logic                     bad_req;
  logic                     done_ev;
  logic                     tmo_exp;

  regacc_pack #(
    .MAX_ITEMS(MAX_ITEMS), .BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W), .WCNT_W(WCNT_W)
  ) u_pack (
    .op(op_q), .count(cnt_q), .addr(addr_q), .data(data_q),
    .payload(payload), .size(size), .nwords(nwords)
  );

  regacc_timer #(.W(TMO_W)) u_timer (
    .clk(clk), .rst(rst), .run(state == S_WAIT), .limit(tmo_q), .expired(tmo_exp)
  );

  assign bad_req  = (req_count == '0) || (int'(req_count) > MAX_ITEMS) || (req_op == OP_RSVD);
  assign done_ev  = irq_q ? mb_irq : !mb_busy;
  assign rwords   = WCNT_W'((int'(cnt_q) + 3) >> 2);
  assign cmd_word = {8'h00, size, 2'b00, op_q, 3'b000, irq_q, MSG_POWER_REG};

  always_comb begin
    rd_result = '0;
    for (int i = 0; i < MAX_ITEMS; i++)
      if (i < int'(cnt_q)) rd_result[8*i +: 8] = rbuf_q[8*i +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      req_ready  <= 1'b1;
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_data   <= '0;
      mb_wr      <= 1'b0;
      mb_rd      <= 1'b0;
      mb_addr    <= '0;
      mb_wdata   <= '0;
      op_q       <= '0;
      cnt_q      <= '0;
      addr_q     <= '0;
      data_q     <= '0;
      irq_q      <= 1'b0;
      tmo_q      <= '0;
      widx       <= '0;
      rbuf_q     <= '0;
    end else begin
      mb_wr     <= 1'b0;
      mb_rd     <= 1'b0;
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid && req_ready) begin
          op_q      <= req_op;
          cnt_q     <= req_count;
          addr_q    <= req_addr;
          data_q    <= req_data;
          irq_q     <= use_irq;
          tmo_q     <= timeout_cycles;
          widx      <= '0;
          req_ready <= 1'b0;
          state     <= bad_req ? S_BAD : S_WBUF;
        end
        S_BAD: begin
          rsp_valid  <= 1'b1;
          rsp_status <= ST_BADREQ;
          rsp_data   <= '0;
          req_ready  <= 1'b1;
          state      <= S_IDLE;
        end
        S_WBUF: begin
          mb_wr    <= 1'b1;
          mb_addr  <= WBUF_OFS + (MB_AW'(widx) << 2);
          mb_wdata <= payload[32*widx +: 32];
          if (widx == nwords - 1'b1) state <= S_CMD;
          else                       widx  <= widx + 1'b1;
        end
        S_CMD: begin
          mb_wr    <= 1'b1;
          mb_addr  <= CMD_OFS;
          mb_wdata <= cmd_word;
          state    <= S_HOLD;
        end
        S_HOLD: state <= S_WAIT;
        S_WAIT: begin
          if (done_ev) begin
            if (mb_err) begin
              rsp_valid  <= 1'b1;
              rsp_status <= ST_IOERR;
              rsp_data   <= '0;
              req_ready  <= 1'b1;
              state      <= S_IDLE;
            end else if (op_q == OP_READ) begin
              widx  <= '0;
              state <= S_RREQ;
            end else begin
              rsp_valid  <= 1'b1;
              rsp_status <= ST_OK;
              rsp_data   <= '0;
              req_ready  <= 1'b1;
              state      <= S_IDLE;
            end
          end else if (tmo_exp) begin
            rsp_valid  <= 1'b1;
            rsp_status <= ST_TIMEOUT;
            rsp_data   <= '0;
            req_ready  <= 1'b1;
            state      <= S_IDLE;
          end
        end
        S_RREQ: begin
          mb_rd   <= 1'b1;
          mb_addr <= RBUF_OFS + (MB_AW'(widx) << 2);
          state   <= S_RGAP;
        end
        S_RGAP: state <= S_RCAP;
        S_RCAP: begin
          rbuf_q[32*widx +: 32] <= mb_rdata;
          if (widx == rwords - 1'b1) state <= S_RDONE;
          else begin
            widx  <= widx + 1'b1;
            state <= S_RREQ;
          end
        end
        S_RDONE: begin
          rsp_valid  <= 1'b1;
          rsp_status <= ST_OK;
          rsp_data   <= rd_result;
          req_ready  <= 1'b1;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_READY_LOW: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE) |-> !req_ready); // R11
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R11
  AST_BAD_SILENT: assert property (@(posedge clk) disable iff (rst)
    (state == S_BAD) |-> (!mb_wr && !mb_rd)); // R7
  AST_CMD_TYPE: assert property (@(posedge clk) disable iff (rst)
    (mb_wr && mb_addr == CMD_OFS) |-> (mb_wdata[7:0] == MSG_POWER_REG && mb_wdata[15:12] == {2'b00, op_q})); // R1
  AST_WBUF_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (mb_wr && mb_addr != CMD_OFS) |-> (mb_addr >= WBUF_OFS && mb_addr < WBUF_OFS + MB_AW'(BUF_BYTES))); // R6
  AST_TMO_NO_READ: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT && tmo_exp && !done_ev) |=> (!mb_rd && state == S_IDLE)); // R10
endmodule

// File: tb/test_regacc_seq.sv
module test_regacc_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic [2:0]  req_count = '0;
  logic [79:0] req_addr = '0;
  logic [39:0] req_data = '0;
  logic        use_irq = 1'b0;
  logic [15:0] timeout_cycles = 16'd64;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [39:0] rsp_data;
  logic        mb_wr, mb_rd;
  logic [7:0]  mb_addr;
  logic [31:0] mb_wdata;
  logic [31:0] mb_rdata;
  logic        mb_busy, mb_err, mb_irq;

  regacc_seq i_regacc_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_count(req_count), .req_addr(req_addr), .req_data(req_data),
    .use_irq(use_irq), .timeout_cycles(timeout_cycles),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_data(rsp_data),
    .mb_wr(mb_wr), .mb_rd(mb_rd), .mb_addr(mb_addr), .mb_wdata(mb_wdata),
    .mb_rdata(mb_rdata), .mb_busy(mb_busy), .mb_err(mb_err), .mb_irq(mb_irq)
  );

  // mailbox model
  logic [31:0] wbuf [4];
  logic [31:0] rbuf [4];
  logic [31:0] cmd_seen;
  int          wr_words, cmd_writes, rd_count, lat_cnt;
  int          plan_lat = 0;
  bit          plan_err = 0, plan_hang = 0, model_clr = 0;

  always @(posedge clk) begin
    mb_irq <= 1'b0;
    if (rst || model_clr) begin
      mb_busy <= 1'b0; mb_err <= 1'b0; mb_rdata <= '0;
      wr_words <= 0; cmd_writes <= 0; rd_count <= 0; lat_cnt <= 0; cmd_seen <= '0;
      for (int k = 0; k < 4; k++) wbuf[k] <= '0;
    end else begin
      if (mb_wr) begin
        if (mb_addr == 8'h00) begin
          cmd_seen <= mb_wdata; cmd_writes <= cmd_writes + 1;
          mb_busy <= 1'b1; mb_err <= 1'b0; lat_cnt <= plan_lat;
        end else begin
          wbuf[mb_addr[3:2]] <= mb_wdata; wr_words <= wr_words + 1;
        end
      end else if (mb_busy && !plan_hang) begin
        if (lat_cnt == 0) begin
          mb_busy <= 1'b0; mb_irq <= 1'b1; mb_err <= plan_err;
        end else lat_cnt <= lat_cnt - 1;
      end
      if (mb_rd) begin
        mb_rdata <= rbuf[mb_addr[3:2]];
        rd_count <= rd_count + 1;
      end
    end
  end

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] exp_payload(input logic [1:0] op, input int n,
                                                input logic [79:0] a, input logic [39:0] d);
    logic [127:0] p = '0;
    int na = (op == 2) ? 1 : n;
    for (int i = 0; i < na; i++) begin
      p[16*i +: 8]     = a[16*i +: 8];
      p[16*i + 8 +: 8] = a[16*i + 8 +: 8];
    end
    if (op == 0) for (int i = 0; i < n; i++) p[8*(2*n+i) +: 8] = d[8*i +: 8];
    if (op == 2) begin p[23:16] = d[7:0]; p[31:24] = d[15:8]; end
    return p;
  endfunction

  function automatic int exp_size(input logic [1:0] op, input int n);
    return (op == 0) ? 3*n : (op == 1) ? 2*n : 4;
  endfunction

  task automatic run_req(input logic [1:0] op, input int n, input logic [79:0] a,
                         input logic [39:0] d, input bit irqm, input int lat,
                         input bit perr, input bit hang, input logic [15:0] tmo);
    logic [1:0]   st_exp;
    logic [127:0] p;
    logic [39:0]  rd_exp;
    int sz, nw, guard;
    bit seen;
    @(negedge clk);
    model_clr = 1; plan_lat = lat; plan_err = perr; plan_hang = hang;
    for (int k = 0; k < 4; k++) rbuf[k] = $urandom;
    @(negedge clk);
    model_clr = 0;
    req_op = op; req_count = 3'(n); req_addr = a; req_data = d;
    use_irq = irqm; timeout_cycles = tmo; req_valid = 1'b1;
    guard = 0;
    do begin
      seen = req_ready;
      @(negedge clk);
      guard++;
    end while (!seen && guard < 1000);
    req_valid = 1'b0;
    guard = 0;
    while (!rsp_valid && guard < 2000) begin @(negedge clk); guard++; end
    if (n == 0 || n > 5 || op == 3) st_exp = 2'd3;
    else if (hang) st_exp = 2'd2;
    else if (perr) st_exp = 2'd1;
    else st_exp = 2'd0;
    chk("R11 response pulse", {127'b0, rsp_valid}, 128'd1);
    chk("R8 R9 R10 status", {126'b0, rsp_status}, {126'b0, st_exp});
    if (st_exp == 2'd3) begin
      chk("R7 no mailbox write", 128'(wr_words + cmd_writes), 128'd0);
      chk("R7 no mailbox read", 128'(rd_count), 128'd0);
    end else begin
      sz = exp_size(op, n);
      nw = (sz + 3) / 4;
      p  = exp_payload(op, n, a, d);
      chk("R1 command word", {96'b0, cmd_seen},
          {96'b0, 8'h00, 8'(sz), 2'b00, op, 3'b000, irqm, 8'hFF});
      chk("R1 single command", 128'(cmd_writes), 128'd1);
      chk("R6 payload word count", 128'(wr_words), 128'(nw));
      chk("R2 R3 R5 R6 payload", {wbuf[3], wbuf[2], wbuf[1], wbuf[0]}, p);
      if (st_exp == 2'd0 && op == 1) begin
        rd_exp = '0;
        for (int i = 0; i < n; i++) rd_exp[8*i +: 8] = rbuf[i/4][8*(i%4) +: 8];
        chk("R4 read data", {88'b0, rsp_data}, {88'b0, rd_exp});
        chk("R4 read word count", 128'(rd_count), 128'((n + 3) / 4));
      end else
        chk("R10 no read access", 128'(rd_count), 128'd0);
    end
    @(negedge clk);
    chk("R11 pulse ends", {127'b0, rsp_valid}, 128'd0);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 ready after reset", {127'b0, req_ready}, 128'd1);
    chk("R12 idle outputs", {125'b0, rsp_valid, mb_wr, mb_rd}, 128'd0);

    // directed corners
    run_req(2'd0, 1, 80'h1234, 40'hA5, 0, 2, 0, 0, 16'd64);           // R3
    run_req(2'd0, 5, 80'h1111_2222_3333_4444_5555, 40'h0102030405, 1, 1, 0, 0, 16'd64); // R3
    run_req(2'd1, 5, 80'hAAAA_BBBB_CCCC_DDDD_EEEE, '0, 0, 3, 0, 0, 16'd64); // R4
    run_req(2'd1, 4, 80'h0000_0123_4567_89AB_CDEF, '0, 1, 0, 0, 0, 16'd64); // R4
    run_req(2'd2, 3, 80'hFFFF_FFFF_BEEF, 40'h00_0000_F00F, 0, 1, 0, 0, 16'd64); // R5
    run_req(2'd0, 0, 80'h1, 40'h1, 0, 1, 0, 0, 16'd64);              // R7
    run_req(2'd1, 6, 80'h1, 40'h1, 0, 1, 0, 0, 16'd64);              // R7
    run_req(2'd3, 2, 80'h1, 40'h1, 0, 1, 0, 0, 16'd64);              // R7
    run_req(2'd1, 2, 80'h5678_9ABC, '0, 0, 2, 1, 0, 16'd64);         // R8 error
    run_req(2'd0, 2, 80'h5678_9ABC, 40'h7788, 1, 4, 1, 0, 16'd64);   // R9 error
    run_req(2'd1, 3, 80'h1_0002_0003, '0, 0, 0, 0, 1, 16'd20);       // R10 poll
    run_req(2'd0, 1, 80'h42, 40'h24, 1, 0, 0, 1, 16'd5);             // R10 irq

    // random mix
    for (int it = 0; it < 60; it++) begin
      logic [79:0] ra;
      logic [39:0] rd;
      ra = {$urandom, $urandom, 16'($urandom)};
      rd = {8'($urandom), $urandom};
      run_req(2'($urandom % 3), 1 + int'($urandom % 5), ra, rd, 1'($urandom),
              int'($urandom % 7), ($urandom % 4) == 0, 0, 16'd64);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule